// File: doc/BRIEF.md
# Exhaustive-Service Matcher with Permutation Walk

This block schedules one slot at a time for a 4x4 crossbar fed by virtual output queues. On each slot strobe it reads the queue-length matrix and builds two candidate input-to-output permutations.

The first candidate starts from the match applied in the previous slot. Every pair whose queue still holds cells stays connected. Inputs and outputs that were released are re-paired with one round-robin request, grant and accept pass. Anything still left over is paired in ascending order.

The second candidate is the current step of a walk that visits all 24 permutations by swapping adjacent positions. The walk makes one step per slot.

The block sums the queue lengths under each candidate and applies the heavier one. A tie goes to the held candidate. It presents the chosen permutation and its weight one clock after the strobe.

Holding pairs until their queue drains spreads the cost of forming a match over every cell in that queue. Comparing against the walk means every permutation is considered once every 24 slots, whatever the held match is doing.

Top module: `ehw_matcher`

## Requirements
- R1: While rst_ni is low and after it is released, match_o maps input i to output i (value 8'hE4), weight_o is 0 and valid_o is low.
- R2: valid_o is high for exactly the one clock that follows a clock in which slot_i is high. match_o and weight_o change only at that edge and otherwise hold their value.
- R3: Every applied match is a permutation. Field i of match_o, at bits [2i+1:2i], is the output given to input i, and each output appears exactly once.
- R4: weight_o equals the sum, over all inputs i, of the queue length of input i toward output match_o[i]. The lengths are those on qlen_i in the slot cycle. Entry (i,j) is the unsigned 8-bit field at bits [(4i+j)*8+7:(4i+j)*8].
- R5: In the held candidate, every pair of the previously applied match whose queue length is nonzero in the slot cycle is kept.
- R6: Released inputs and outputs are re-paired in one pass. Each released input requests every released output whose queue toward it is nonzero. Each output grants the first requesting input found scanning upward, cyclically, from its grant pointer. Each input accepts the first granting output found scanning upward, cyclically, from its accept pointer. On an accept, the input pointer moves to one past the accepted output and that output's pointer moves to one past the input. All pointers reset to 0.
- R7: Inputs still unpaired after that pass take the remaining outputs in ascending order, lowest input first. With all queues empty the held candidate is therefore the identity.
- R8: The walk candidate starts at the identity after reset and advances once per slot by swapping one adjacent pair, in plain-changes order. At each step the largest element that can move does so. An element can move when the neighbour in its direction is smaller. Every element starts moving toward position 0, and each move reverses the direction of all larger elements. When no element can move, positions 0 and 1 swap and all directions return to the start. The walk repeats every 24 slots.
- R9: The walk candidate is applied only when its weight is strictly greater than that of the held candidate. On a tie the held candidate is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| slot_i | input | 1 | Slot strobe; one scheduling decision per high cycle |
| qlen_i | input | 128 | Queue-length matrix, 16 fields of 8 bits, entry (i,j) at field 4i+j |
| match_o | output | 8 | Applied permutation, 2-bit output index per input |
| weight_o | output | 10 | Weight of the applied permutation |
| valid_o | output | 1 | High one cycle after each slot strobe |

## Verification
The bench steps a reference model alongside the design through sparse, draining queue matrices over several full walk periods. A walk that loses its place or repeats early, or a tie resolved toward the walk, then shows up as a wrong permutation.

Ones that are easy to miss:
- **All queues empty.** After activity, every held pair is released, and the left-over fill must return the identity with weight 0. A fill that skipped outputs would produce a non-permutation.
- **Request conflicts.** These exercise the grant and accept pointers. A pointer moved on a grant that was not accepted, or not moved at all, diverges within a few slots.
- **Mid-run reset.** This must restore the identity match and restart the walk and the pointers.

// File: rtl/ehw_pkg.sv
package ehw_pkg;
  localparam int PORTS_DEF = 4;
  localparam int QLEN_W_DEF = 8;

  // cyclic index fold for values in [0, 2n)
  function automatic int wrap(input int v, input int n);
    return (v >= n) ? v - n : v;
  endfunction
endpackage

// File: rtl/ehw_weight.sv
module ehw_weight #(
  parameter int N  = ehw_pkg::PORTS_DEF,
  parameter int QW = ehw_pkg::QLEN_W_DEF,
  localparam int IW = $clog2(N),
  localparam int WW = QW + $clog2(N)
) (
  input  logic [N*N*QW-1:0] qlen_i,
  input  logic [N*IW-1:0]   perm_i,
  output logic [WW-1:0]     weight_o
);
  always_comb begin
    weight_o = '0;
    for (int i = 0; i < N; i++)
      weight_o += WW'(qlen_i[(i*N + int'(perm_i[i*IW +: IW]))*QW +: QW]);
  end
endmodule

// File: rtl/ehw_walk.sv
module ehw_walk #(
  parameter int N = ehw_pkg::PORTS_DEF,
  localparam int IW = $clog2(N)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            step_i,
  output logic [N*IW-1:0] perm_o
);
  logic [IW-1:0] perm_q [N];
  logic [IW-1:0] perm_n [N];
  logic [N-1:0]  dir_q, dir_n;  // per value, 1 = toward position 0
  logic          mob_hit;
  logic [IW-1:0] mob_v;
  int            mob_k, lo, hi, nb;

  always_comb begin
    mob_hit = 1'b0;
    mob_v   = '0;
    mob_k   = 0;
    for (int k = 0; k < N; k++) begin
      lo = (k == 0) ? 0 : k - 1;
      hi = (k == N - 1) ? N - 1 : k + 1;
      if (dir_q[perm_q[k]] ? (k > 0 && perm_q[lo] < perm_q[k])
                           : (k < N - 1 && perm_q[hi] < perm_q[k])) begin
        if (!mob_hit || perm_q[k] > mob_v) begin
          mob_hit = 1'b1;
          mob_v   = perm_q[k];
          mob_k   = k;
        end
      end
    end
    perm_n = perm_q;
    dir_n  = dir_q;
    nb     = 0;
    if (mob_hit) begin
      nb = dir_q[mob_v] ? mob_k - 1 : mob_k + 1;
      perm_n[mob_k] = perm_q[nb];
      perm_n[nb]    = mob_v;
      for (int v = 0; v < N; v++)
        if (IW'(v) > mob_v) dir_n[v] = ~dir_q[v];
    end else begin
      // end of sequence: one adjacent swap closes the cycle
      perm_n[0] = perm_q[1];
      perm_n[1] = perm_q[0];
      dir_n     = '1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < N; k++) perm_q[k] <= IW'(k);
      dir_q <= '1;
    end else if (step_i) begin
      perm_q <= perm_n;
      dir_q  <= dir_n;
    end
  end

  always_comb
    for (int k = 0; k < N; k++) perm_o[k*IW +: IW] = perm_q[k];
endmodule

// File: rtl/ehw_exhaust.sv
module ehw_exhaust #(
  parameter int N  = ehw_pkg::PORTS_DEF,
  parameter int QW = ehw_pkg::QLEN_W_DEF,
  localparam int IW = $clog2(N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slot_i,
  input  logic [N*N*QW-1:0] qlen_i,
  input  logic [N*IW-1:0]   prev_i,
  output logic [N*IW-1:0]   cand_o
);
  import ehw_pkg::wrap;

  logic [IW-1:0] gptr_q [N];
  logic [IW-1:0] aptr_q [N];
  logic [IW-1:0] gnt_in [N];
  logic [IW-1:0] acc_out [N];
  logic [IW-1:0] cand [N];
  logic [N-1:0]  in_busy, out_busy, gnt_v, acc_v, out_used;
  logic          fill_hit;
  int            ii, jj;

  function automatic logic [QW-1:0] qat(input logic [N*N*QW-1:0] q, input int i, input int j);
    return q[(i*N + j)*QW +: QW];
  endfunction

  always_comb begin
    in_busy  = '0;
    out_busy = '0;
    for (int i = 0; i < N; i++) begin
      cand[i] = prev_i[i*IW +: IW];
      if (qat(qlen_i, i, int'(cand[i])) != '0) begin
        in_busy[i]        = 1'b1;
        out_busy[cand[i]] = 1'b1;
      end
    end
    // grant
    gnt_v = '0;
    ii    = 0;
    for (int j = 0; j < N; j++) begin
      gnt_in[j] = '0;
      for (int k = 0; k < N; k++) begin
        ii = wrap(int'(gptr_q[j]) + k, N);
        if (!gnt_v[j] && !out_busy[j] && !in_busy[ii] && qat(qlen_i, ii, j) != '0) begin
          gnt_v[j]  = 1'b1;
          gnt_in[j] = IW'(ii);
        end
      end
    end
    // accept
    acc_v = '0;
    jj    = 0;
    for (int i = 0; i < N; i++) begin
      acc_out[i] = '0;
      for (int k = 0; k < N; k++) begin
        jj = wrap(int'(aptr_q[i]) + k, N);
        if (!acc_v[i] && !in_busy[i] && gnt_v[jj] && gnt_in[jj] == IW'(i)) begin
          acc_v[i]   = 1'b1;
          acc_out[i] = IW'(jj);
        end
      end
    end
    out_used = out_busy;
    for (int i = 0; i < N; i++)
      if (acc_v[i]) begin
        cand[i]              = acc_out[i];
        out_used[acc_out[i]] = 1'b1;
      end
    // left-over fill keeps the result a full permutation
    fill_hit = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (!in_busy[i] && !acc_v[i]) begin
        fill_hit = 1'b0;
        for (int j = 0; j < N; j++)
          if (!fill_hit && !out_used[j]) begin
            cand[i]     = IW'(j);
            out_used[j] = 1'b1;
            fill_hit    = 1'b1;
          end
      end
    end
    for (int i = 0; i < N; i++) cand_o[i*IW +: IW] = cand[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) begin
        gptr_q[i] <= '0;
        aptr_q[i] <= '0;
      end
    end else if (slot_i) begin
      for (int i = 0; i < N; i++)
        if (acc_v[i]) begin
          aptr_q[i]          <= IW'(wrap(int'(acc_out[i]) + 1, N));
          gptr_q[acc_out[i]] <= IW'(wrap(i + 1, N));
        end
    end
  end
endmodule

// File: rtl/ehw_matcher.sv
module ehw_matcher #(
  parameter int N  = ehw_pkg::PORTS_DEF,
  parameter int QW = ehw_pkg::QLEN_W_DEF,
  localparam int IW = $clog2(N),
  localparam int WW = QW + $clog2(N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slot_i,
  input  logic [N*N*QW-1:0] qlen_i,
  output logic [N*IW-1:0]   match_o,
  output logic [WW-1:0]     weight_o,
  output logic              valid_o
);
  logic [N*IW-1:0] match_q, walk_perm, exh_perm;
  logic [WW-1:0]   w_walk, w_exh, weight_q;
  logic            valid_q, take_walk;

  ehw_walk #(.N(N)) u_walk (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .step_i(slot_i),
    .perm_o(walk_perm)
  );

  ehw_exhaust #(.N(N), .QW(QW)) u_exh (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .slot_i(slot_i),
    .qlen_i(qlen_i),
    .prev_i(match_q),
    .cand_o(exh_perm)
  );

  ehw_weight #(.N(N), .QW(QW)) u_w_walk (
    .qlen_i  (qlen_i),
    .perm_i  (walk_perm),
    .weight_o(w_walk)
  );

  ehw_weight #(.N(N), .QW(QW)) u_w_exh (
    .qlen_i  (qlen_i),
    .perm_i  (exh_perm),
    .weight_o(w_exh)
  );

  // strict compare: ties stay with the held match
  assign take_walk = w_walk > w_exh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) match_q[i*IW +: IW] <= IW'(i);
      weight_q <= '0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= slot_i;
      if (slot_i) begin
        match_q  <= take_walk ? walk_perm : exh_perm;
        weight_q <= take_walk ? w_walk : w_exh;
      end
    end
  end

  assign match_o  = match_q;
  assign weight_o = weight_q;
  assign valid_o  = valid_q;
endmodule

// File: rtl/ehw_matcher_chk.sv
module ehw_matcher_chk #(
  parameter int N  = ehw_pkg::PORTS_DEF,
  parameter int QW = ehw_pkg::QLEN_W_DEF,
  localparam int IW = $clog2(N),
  localparam int WW = QW + $clog2(N)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              slot_i,
  input logic [N*N*QW-1:0] qlen_i,
  input logic [N*IW-1:0]   match_o,
  input logic [WW-1:0]     weight_o,
  input logic              valid_o
);
  logic [N*N*QW-1:0] q_snap;
  logic [N-1:0]      out_hit;
  logic [WW-1:0]     held_sum, snap_sum;

  function automatic logic [WW-1:0] psum(input logic [N*N*QW-1:0] q, input logic [N*IW-1:0] m);
    logic [WW-1:0] s;
    s = '0;
    for (int i = 0; i < N; i++) s += WW'(q[(i*N + int'(m[i*IW +: IW]))*QW +: QW]);
    return s;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) q_snap <= '0;
    else if (slot_i) q_snap <= qlen_i;

  always_comb begin
    out_hit = '0;
    for (int i = 0; i < N; i++) out_hit[match_o[i*IW +: IW]] = 1'b1;
    held_sum = psum(qlen_i, match_o);
    snap_sum = psum(q_snap, match_o);
  end

  assert_valid_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_i |=> valid_o);
  assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !slot_i |=> (!valid_o && $stable(match_o) && $stable(weight_o)));
  assert_permutation_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (&out_hit));
  assert_weight_sum_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (weight_o == snap_sum));
  assert_keep_held_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_i |=> (weight_o >= $past(held_sum)));
endmodule

bind ehw_matcher ehw_matcher_chk #(.N(N), .QW(QW)) u_chk (.*);

// File: tb/test_ehw_matcher.sv
module test_ehw_matcher;
  localparam int N = 4, QW = 8, IW = 2, WW = 10;

  logic              clk = 1'b0, rst_ni = 1'b0, slot_i = 1'b0;
  logic [N*N*QW-1:0] qlen_i = '0;
  logic [N*IW-1:0]   match_o;
  logic [WW-1:0]     weight_o;
  logic              valid_o;

  ehw_matcher i_ehw_matcher (.clk_i(clk), .rst_ni(rst_ni), .slot_i(slot_i), .qlen_i(qlen_i),
                             .match_o(match_o), .weight_o(weight_o), .valid_o(valid_o));

  always #10 clk = ~clk;

  int n_chk = 0, n_err = 0;
  int m_prev[4], m_perm[4], m_dir[4], m_gp[4], m_ap[4], e_m[4], e_w;
  logic [31:0]  lfsr = 32'hACE1_2F07;
  logic [127:0] cur_q;

  localparam logic [127:0] TBL [8] = '{
    128'h01000000_00010000_00000100_00000001,
    128'h00000000_00000000_00000005_00000903,
    128'h07000300_00020000_06000000_00000004,
    128'h00000000_00000000_00000000_0000FF00,
    128'h11111111_11111111_11111111_11111111,
    128'h00400000_80000000_00000020_00001000,
    128'hFF000000_00FF0000_0000FF00_000000FF,
    128'h00000A00_0B000000_000000C0_0D000000
  };

  function automatic int qv(input logic [127:0] q, input int i, input int j);
    return int'(q[(i*4 + j)*8 +: 8]);
  endfunction

  function automatic logic [7:0] exp_flat();
    logic [7:0] f;
    f = '0;
    for (int i = 0; i < 4; i++) f[i*2 +: 2] = 2'(e_m[i]);
    return f;
  endfunction

  task automatic chk(input string tg, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tg, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin
      m_prev[i] = i; m_perm[i] = i; m_dir[i] = 1; m_gp[i] = 0; m_ap[i] = 0;
    end
  endtask

  task automatic model_slot(input logic [127:0] q);
    int z[4], g[4], wz, wh, bv, bk, nb, t;
    bit ib[4], ob[4], hit, mob;
    for (int i = 0; i < 4; i++) begin ib[i] = 0; ob[i] = 0; end
    for (int i = 0; i < 4; i++) begin
      z[i] = -1;
      if (qv(q, i, m_prev[i]) != 0) begin z[i] = m_prev[i]; ib[i] = 1; ob[m_prev[i]] = 1; end
    end
    for (int j = 0; j < 4; j++) begin
      g[j] = -1;
      if (!ob[j])
        for (int k = 0; k < 4; k++) begin
          t = (m_gp[j] + k) % 4;
          if (g[j] < 0 && !ib[t] && qv(q, t, j) != 0) g[j] = t;
        end
    end
    for (int i = 0; i < 4; i++)
      if (!ib[i])
        for (int k = 0; k < 4; k++) begin
          t = (m_ap[i] + k) % 4;
          if (z[i] < 0 && g[t] == i) z[i] = t;
        end
    for (int i = 0; i < 4; i++)
      if (!ib[i] && z[i] >= 0) begin
        ob[z[i]] = 1; m_ap[i] = (z[i] + 1) % 4; m_gp[z[i]] = (i + 1) % 4;
      end
    for (int i = 0; i < 4; i++)
      if (z[i] < 0)
        for (int j = 0; j < 4; j++)
          if (z[i] < 0 && !ob[j]) begin z[i] = j; ob[j] = 1; end
    wz = 0; wh = 0;
    for (int i = 0; i < 4; i++) begin wz += qv(q, i, z[i]); wh += qv(q, i, m_perm[i]); end
    for (int i = 0; i < 4; i++) e_m[i] = (wh > wz) ? m_perm[i] : z[i];
    e_w = (wh > wz) ? wh : wz;
    for (int i = 0; i < 4; i++) m_prev[i] = e_m[i];
    // plain-changes step
    hit = 0; bv = 0; bk = 0;
    for (int k = 0; k < 4; k++) begin
      mob = 0;
      if (m_dir[m_perm[k]] == 1 && k > 0)
        if (m_perm[k-1] < m_perm[k]) mob = 1;
      if (m_dir[m_perm[k]] == 0 && k < 3)
        if (m_perm[k+1] < m_perm[k]) mob = 1;
      if (mob && (!hit || m_perm[k] > bv)) begin hit = 1; bv = m_perm[k]; bk = k; end
    end
    if (hit) begin
      nb = (m_dir[bv] == 1) ? bk - 1 : bk + 1;
      m_perm[bk] = m_perm[nb]; m_perm[nb] = bv;
      for (int v = 0; v < 4; v++) if (v > bv) m_dir[v] = 1 - m_dir[v];
    end else begin
      t = m_perm[0]; m_perm[0] = m_perm[1]; m_perm[1] = t;
      for (int v = 0; v < 4; v++) m_dir[v] = 1;
    end
  endtask

  task automatic do_slot(input logic [127:0] q, input string tg);
    logic [3:0] seen;
    @(negedge clk);
    qlen_i = q; slot_i = 1'b1;
    model_slot(q);
    @(negedge clk);
    slot_i = 1'b0;
    chk({"R2 valid ", tg}, 64'(valid_o), 64'd1);
    chk({"R5/R6/R7/R8/R9 match ", tg}, 64'(match_o), 64'(exp_flat()));
    chk({"R4 weight ", tg}, 64'(weight_o), 64'(e_w));
    seen = '0;
    for (int i = 0; i < 4; i++) seen[match_o[i*2 +: 2]] = 1'b1;
    chk({"R3 permutation ", tg}, 64'(seen), 64'hF);
  endtask

  task automatic lfsr_step();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
  endtask

  // drain matched VOQs by one cell, then refresh some entries
  task automatic evolve_q();
    for (int i = 0; i < 4; i++)
      if (cur_q[(i*4 + e_m[i])*8 +: 8] != 0)
        cur_q[(i*4 + e_m[i])*8 +: 8] = cur_q[(i*4 + e_m[i])*8 +: 8] - 8'd1;
    for (int e = 0; e < 16; e++) begin
      lfsr_step();
      if (lfsr[3:0] < 4'd3) cur_q[e*8 +: 8] = (lfsr[5:4] == 2'd0) ? 8'(lfsr[13:8] & 6'h07) : 8'(lfsr[13:8]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    chk("R1 reset valid", 64'(valid_o), 64'd0);
    chk("R1 reset match", 64'(match_o), 64'hE4);
    chk("R1 reset weight", 64'(weight_o), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 after release match", 64'(match_o), 64'hE4);

    do_slot('0, "empty");
    chk("R7 empty gives identity", 64'(match_o), 64'hE4);
    @(negedge clk);
    chk("R2 idle valid low", 64'(valid_o), 64'd0);
    chk("R2 idle match held", 64'(match_o), 64'hE4);

    for (int t = 0; t < 8; t++) do_slot(TBL[t], $sformatf("table%0d", t));

    do_slot('0, "drain");
    chk("R7 drained gives identity", 64'(match_o), 64'hE4);
    chk("R7 drained weight", 64'(weight_o), 64'd0);

    cur_q = TBL[2];
    for (int s = 0; s < 72; s++) begin
      do_slot(cur_q, $sformatf("run%0d", s));
      evolve_q();
    end

    @(negedge clk);
    rst_ni = 1'b0;
    model_reset();
    @(negedge clk);
    chk("R1 mid-run reset match", 64'(match_o), 64'hE4);
    chk("R1 mid-run reset weight", 64'(weight_o), 64'd0);
    rst_ni = 1'b1;
    cur_q = TBL[5];
    for (int s = 0; s < 30; s++) begin
      do_slot(cur_q, $sformatf("rerun%0d", s));
      evolve_q();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule